// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a bank of general-purpose input pins and turns selected pin activity into a single interrupt request. It receives pin levels that are already synchronized to its clock, along with the direction vector of the port. Each pin has its own trigger condition. A pin can trigger while its level matches a chosen polarity. It can trigger on one edge whose direction software selects. It can also trigger on either edge. Edge detection works only on pins configured as inputs.

A detected event sets a sticky bit in a raw status vector. A pin in level mode keeps setting its bit for as long as its level matches, so clearing the bit has no lasting effect while the condition holds. Software reads the trigger configuration, the raw status and the masked status through a simple register port. It acknowledges events by writing ones to a clear register. The interrupt output is high whenever any raw status bit is set and its mask bit is also set.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the sense, both-edge, event, mask and raw status registers all read 0x00, and `irqOut` is low.
- R2: The configuration registers read back the last value written. Their offsets are: trigger kind at 0x404 (1 = level, 0 = edge), any-edge enable at 0x408, polarity at 0x40C, mask at 0x410. Bit n of each register belongs to pin n. A read of any unmapped offset, or of the clear offset, returns 0x00.
- R3: When pin n has sense 0 and any-edge 1, any change of its level sets raw status bit n (offset 0x414). The bit is visible one clock after the new level is presented.
- R4: When pin n has sense 0 and any-edge 0, raw status bit n is set only when the new level equals polarity bit n. Polarity 1 selects rising edges and polarity 0 selects falling edges. The opposite edge leaves the bit clear.
- R5: When pin n has sense 1, raw status bit n is set on every clock in which the pin level equals polarity bit n. A clear of that bit while the level still matches leaves the bit set.
- R6: While direction bit n is 1 (output), a change of pin n never sets status through edge detection.
- R7: A write to offset 0x41C clears each raw status bit where the written value has a 1. Bits written as 0 keep their value. Status bits never fall for any other reason.
- R8: When a clear and a new event hit the same bit on the same clock, the bit stays set.
- R9: Masked status (offset 0x418) equals raw status AND mask, and `irqOut` is high exactly when masked status is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinLevel | input | 8 | Synchronized pin levels |
| pinDir | input | 8 | Port direction, 1 = output |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset for reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | Interrupt request |

## Verification
Raw status is sticky. A wrongly set or dropped status bit therefore stays wrong until software clears it. The error shows at offset 0x414 on the first read after the faulty clock, and through the mask it also shows on `irqOut` in that same cycle. A wrong edge reference shows one clock after a pin change, either as a missing status bit or as a spurious one. The directed scenarios read status after every stimulus, so they catch this. A mis-decoded configuration write shows on the read-back of the register it was aimed at, or on the register that changed instead.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Write strobes decoded by the control block
  typedef struct packed {
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrMask;
    logic wrClear;
  } ctrlStrb_t;

  // Read source selection
  typedef enum logic [2:0] {
    RD_NONE   = 3'd0,
    RD_SENSE  = 3'd1,
    RD_BOTH   = 3'd2,
    RD_EVENT  = 3'd3,
    RD_MASK   = 3'd4,
    RD_RAW    = 3'd5,
    RD_MASKED = 3'd6
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFS_SENSE  = ADDR_W'('h404),
  parameter logic [ADDR_W-1:0] OFS_BOTH   = ADDR_W'('h408),
  parameter logic [ADDR_W-1:0] OFS_EVENT  = ADDR_W'('h40C),
  parameter logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'('h410),
  parameter logic [ADDR_W-1:0] OFS_RAW    = ADDR_W'('h414),
  parameter logic [ADDR_W-1:0] OFS_MASKED = ADDR_W'('h418),
  parameter logic [ADDR_W-1:0] OFS_CLEAR  = ADDR_W'('h41C)
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrb_t         strb,
  output rdSel_t            rdSel
);

  logic hitSense, hitBoth, hitEvent, hitMask, hitRaw, hitMasked, hitClear;

  assign hitSense  = (regAddr == OFS_SENSE);
  assign hitBoth   = (regAddr == OFS_BOTH);
  assign hitEvent  = (regAddr == OFS_EVENT);
  assign hitMask   = (regAddr == OFS_MASK);
  assign hitRaw    = (regAddr == OFS_RAW);
  assign hitMasked = (regAddr == OFS_MASKED);
  assign hitClear  = (regAddr == OFS_CLEAR);

  // Write strobes; the status offsets are read-only
  always_comb begin
    strb         = '0;
    strb.wrSense = regWrEn && hitSense;
    strb.wrBoth  = regWrEn && hitBoth;
    strb.wrEvent = regWrEn && hitEvent;
    strb.wrMask  = regWrEn && hitMask;
    strb.wrClear = regWrEn && hitClear;
  end

  // Read selection; clear offset and unmapped offsets read as zero
  always_comb begin
    rdSel = RD_NONE;
    if (hitSense)       rdSel = RD_SENSE;
    else if (hitBoth)   rdSel = RD_BOTH;
    else if (hitEvent)  rdSel = RD_EVENT;
    else if (hitMask)   rdSel = RD_MASK;
    else if (hitRaw)    rdSel = RD_RAW;
    else if (hitMasked) rdSel = RD_MASKED;
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  rdSel_t              rdSel,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] pinDir,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] rawStatus,
  output logic [NUM_PINS-1:0] maskReg,
  output logic [NUM_PINS-1:0] eventHits,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] senseReg, bothReg, eventReg;
  logic [NUM_PINS-1:0] prevLevel;
  logic [NUM_PINS-1:0] clearBits;
  logic [NUM_PINS-1:0] statusNext;
  logic [NUM_PINS-1:0] maskedStatus;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseReg <= '0;
      bothReg  <= '0;
      eventReg <= '0;
      maskReg  <= '0;
    end else begin
      if (strb.wrSense) senseReg <= wrData;
      if (strb.wrBoth)  bothReg  <= wrData;
      if (strb.wrEvent) eventReg <= wrData;
      if (strb.wrMask)  maskReg  <= wrData;
    end
  end

  // Edge reference: level seen on the previous clock
  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= '0;
    else       prevLevel <= pinLevel;
  end

  // Per-pin trigger evaluation
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic moved;
    logic polarityMatch;
    logic edgeHit;
    assign moved         = (pinLevel[p] ^ prevLevel[p]) & ~pinDir[p];
    assign polarityMatch = ~(pinLevel[p] ^ eventReg[p]);
    assign edgeHit       = moved & (bothReg[p] | polarityMatch);
    assign eventHits[p]  = senseReg[p] ? polarityMatch : edgeHit;
  end

  // Sticky status: clear first, then new events win
  assign clearBits  = strb.wrClear ? wrData : '0;
  assign statusNext = (rawStatus & ~clearBits) | eventHits;

  always_ff @(posedge clk) begin
    if (!rstN) rawStatus <= '0;
    else       rawStatus <= statusNext;
  end

  assign maskedStatus = rawStatus & maskReg;
  assign irqOut       = |maskedStatus;

  // Read mux
  always_comb begin
    case (rdSel)
      RD_SENSE:  rdData = senseReg;
      RD_BOTH:   rdData = bothReg;
      RD_EVENT:  rdData = eventReg;
      RD_MASK:   rdData = maskReg;
      RD_RAW:    rdData = rawStatus;
      RD_MASKED: rdData = maskedStatus;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] pinDir,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                irqOut
);

  ctrlStrb_t           strb;
  rdSel_t              rdSel;
  logic [NUM_PINS-1:0] rawStatus;
  logic [NUM_PINS-1:0] maskReg;
  logic [NUM_PINS-1:0] eventHits;

  gpio_irq_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  gpio_irq_datapath #(
    .NUM_PINS (NUM_PINS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .wrData    (regWrData),
    .pinLevel  (pinLevel),
    .pinDir    (pinDir),
    .rdData    (regRdData),
    .rawStatus (rawStatus),
    .maskReg   (maskReg),
    .eventHits (eventHits),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrClear,
  input logic [NUM_PINS-1:0] regWrData,
  input logic [NUM_PINS-1:0] rawStatus,
  input logic [NUM_PINS-1:0] maskReg,
  input logic [NUM_PINS-1:0] eventHits,
  input logic                irqOut
);

  logic [NUM_PINS-1:0] clrBits;
  assign clrBits = wrClear ? regWrData : '0;

  // R1: a reset cycle leaves status and mask empty
  a_r1_reset_empty: assert property (@(posedge clk)
    !rstN |=> (rawStatus == '0 && maskReg == '0));

  // R7: status bits fall only where a clear asked for it
  a_r7_sticky_bits: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(rawStatus) & ~rawStatus & ~$past(clrBits)) == '0));

  // R7: cleared bits without a new event are zero afterwards
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    wrClear |=> ((rawStatus & $past(clrBits) & ~$past(eventHits)) == '0));

  // R8: every event lands in status even under a clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (eventHits != '0) |=> ((rawStatus & $past(eventHits)) == $past(eventHits)));

  // R9: the request needs a set status bit
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rawStatus != '0));

endmodule

bind gpio_irq_detect gpio_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrClear   (strb.wrClear),
  .regWrData (regWrData),
  .rawStatus (rawStatus),
  .maskReg   (maskReg),
  .eventHits (eventHits),
  .irqOut    (irqOut)
);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_SENSE  = 12'h404;
  localparam logic [11:0] A_BOTH   = 12'h408;
  localparam logic [11:0] A_EVENT  = 12'h40C;
  localparam logic [11:0] A_MASK   = 12'h410;
  localparam logic [11:0] A_RAW    = 12'h414;
  localparam logic [11:0] A_MASKED = 12'h418;
  localparam logic [11:0] A_CLEAR  = 12'h41C;

  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] pinLevel = '0;
  logic [7:0] pinDir = '0;
  logic       regWrEn = 0;
  logic [11:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut;
  int         nChecks = 0;
  int         nFails = 0;

  gpio_irq_detect u0 (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinDir(pinDir),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic expectReg(input string tag, input logic [11:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic expectIrq(input string tag, input logic exp);
    @(negedge clk);
    #1;
    check(tag, {7'd0, irqOut}, {7'd0, exp});
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    pinLevel = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    expectReg("R1 sense", A_SENSE, 8'h00);
    expectReg("R1 both", A_BOTH, 8'h00);
    expectReg("R1 event", A_EVENT, 8'h00);
    expectReg("R1 mask", A_MASK, 8'h00);
    expectReg("R1 raw", A_RAW, 8'h00);
    expectReg("R1 masked", A_MASKED, 8'h00);
    expectIrq("R1 irq", 1'b0);
  endtask

  task automatic t_readback;
    regWrite(A_SENSE, 8'hA5); expectReg("R2 sense", A_SENSE, 8'hA5);
    regWrite(A_BOTH, 8'h3C);  expectReg("R2 both", A_BOTH, 8'h3C);
    regWrite(A_EVENT, 8'h96); expectReg("R2 event", A_EVENT, 8'h96);
    regWrite(A_MASK, 8'h5A);  expectReg("R2 mask", A_MASK, 8'h5A);
    expectReg("R2 unmapped", 12'h420, 8'h00);
    expectReg("R2 clear reads zero", A_CLEAR, 8'h00);
    regWrite(A_SENSE, 8'h00);
    regWrite(A_BOTH, 8'h00);
    regWrite(A_EVENT, 8'h00);
    regWrite(A_MASK, 8'h00);
    regWrite(A_CLEAR, 8'hFF);
    expectReg("R2 restore raw", A_RAW, 8'h00);
  endtask

  task automatic t_anyEdge;
    regWrite(A_BOTH, 8'h01);
    setPins(8'h01);
    expectReg("R3 rise", A_RAW, 8'h01);
    regWrite(A_CLEAR, 8'h01);
    expectReg("R3 cleared", A_RAW, 8'h00);
    setPins(8'h00);
    expectReg("R3 fall", A_RAW, 8'h01);
    regWrite(A_CLEAR, 8'h01);
    regWrite(A_BOTH, 8'h00);
  endtask

  task automatic t_singleEdge;
    regWrite(A_EVENT, 8'h02);
    setPins(8'h02);
    expectReg("R4 rising selected", A_RAW, 8'h02);
    regWrite(A_CLEAR, 8'h02);
    setPins(8'h00);
    expectReg("R4 falling ignored", A_RAW, 8'h00);
    setPins(8'h04);
    expectReg("R4 rising ignored", A_RAW, 8'h00);
    setPins(8'h00);
    expectReg("R4 falling selected", A_RAW, 8'h04);
    regWrite(A_CLEAR, 8'h04);
  endtask

  task automatic t_level;
    regWrite(A_EVENT, 8'h0A);
    regWrite(A_SENSE, 8'h08);
    expectReg("R5 inactive", A_RAW, 8'h00);
    setPins(8'h08);
    expectReg("R5 active", A_RAW, 8'h08);
    regWrite(A_CLEAR, 8'h08);
    expectReg("R5 reasserts", A_RAW, 8'h08);
    setPins(8'h00);
    regWrite(A_CLEAR, 8'h08);
    expectReg("R5 released", A_RAW, 8'h00);
    regWrite(A_SENSE, 8'h00);
    regWrite(A_EVENT, 8'h00);
  endtask

  task automatic t_direction;
    pinDir = 8'h10;
    regWrite(A_BOTH, 8'h10);
    setPins(8'h10);
    expectReg("R6 output pin ignored", A_RAW, 8'h00);
    pinDir = 8'h00;
    @(negedge clk);
    setPins(8'h00);
    expectReg("R6 input pin detected", A_RAW, 8'h10);
    regWrite(A_CLEAR, 8'h10);
  endtask

  task automatic t_clear;
    regWrite(A_BOTH, 8'hFF);
    setPins(8'hE0);
    expectReg("R7 set", A_RAW, 8'hE0);
    regWrite(A_CLEAR, 8'h40);
    expectReg("R7 partial clear", A_RAW, 8'hA0);
    regWrite(A_CLEAR, 8'hA0);
    expectReg("R7 full clear", A_RAW, 8'h00);
  endtask

  task automatic t_sameCycle;
    @(negedge clk);
    pinLevel = 8'hC0;
    regWrEn = 1; regAddr = A_CLEAR; regWrData = 8'h20;
    @(negedge clk);
    regWrEn = 0;
    expectReg("R8 event beats clear", A_RAW, 8'h20);
    regWrite(A_CLEAR, 8'h20);
    expectReg("R8 later clear", A_RAW, 8'h00);
  endtask

  task automatic t_mask;
    setPins(8'h80);
    expectReg("R9 raw", A_RAW, 8'h40);
    expectReg("R9 masked off", A_MASKED, 8'h00);
    expectIrq("R9 irq off", 1'b0);
    regWrite(A_MASK, 8'h40);
    expectReg("R9 masked on", A_MASKED, 8'h40);
    expectIrq("R9 irq on", 1'b1);
    regWrite(A_MASK, 8'hBF);
    expectIrq("R9 other bits", 1'b0);
    regWrite(A_CLEAR, 8'hFF);
    regWrite(A_MASK, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_readback();
    t_anyEdge();
    t_singleEdge();
    t_level();
    t_direction();
    t_clear();
    t_sameCycle();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule